// File: doc/BRIEF.md
# Pause-Width Frame Transmitter with Keystream Whitening

This block sends a reader-to-card frame of up to 32 bits over a single carrier-enable line. The carrier rests on. Each bit opens with a fixed carrier-off pause, and the carrier then comes back on. The total length of the bit tells the receiver its value. Before the duration is chosen, each frame bit is XORed with one keystream bit. After the last bit, one more pause closes the frame. A new frame cannot begin until a guard interval has passed since the previous frame ended.

The keystream comes in on a valid/ready stream, and one bit is consumed per frame bit. The block raises `ks_ready` only while the carrier is off, starting in the last tick of a pause. A bit is taken on a cycle where both `ks_ready` and `ks_valid` are high. While `ks_valid` is high the source must hold `ks_bit` steady. If the source is not valid when the pause is due to end, the pause stretches until a bit arrives, and the rest of the frame is timed from that point. One clock cycle is one timing tick, at 1.5 ticks per microsecond. All bit deadlines are summed onto one running timestamp, so the schedule does not drift. Control is plain: a `start` strobe that captures the frame word and length, and a one-cycle `done` pulse.

Top module: `pwtx_pause_tx`

## Requirements
- R1: Out of reset, `carrier_on` is 1 while `done` and `ks_ready` are 0. The carrier stays on whenever no frame is in progress.
- R2: Every frame bit starts with exactly PAUSE_T (30) ticks with `carrier_on` low, followed by the carrier high. A bit lasts ONE_T (150) ticks in total for a transmitted 1 and ZERO_T (90) ticks for a transmitted 0. Each bit edge is timed from the previous one.
- R3: Bits go out starting at bit 0 of `frame_data` and moving upward. The transmitted value of frame bit i is `frame_data[i]` XOR the i-th keystream bit taken.
- R4: `ks_ready` is high only while the carrier is off, first in the last tick of a pause. Exactly one keystream bit is taken per frame bit, on a cycle with `ks_ready` and `ks_valid` both high.
- R5: If `ks_valid` is low when a pause is due to end, the pause lasts PAUSE_T plus one extra tick for each cycle in which `ks_ready` is high and `ks_valid` is low. The carrier-on part that follows keeps its normal length.
- R6: After the last bit comes one closing pause of PAUSE_T ticks, and then the carrier returns high. `done` is high for exactly one cycle, the first cycle in which the carrier is back on.
- R7: The first pause of a frame begins GUARD_T (330) ticks after the previous frame's carrier returned high. It begins no earlier than that, and no later if `start` was already seen. When `start` comes after the guard has passed, the carrier drops on the same clock edge that samples `start`. So the idle-high stretch between frames is max(GUARD_T, start sampling edge minus return edge) ticks.
- R8: A `frame_len` of 0 sends only the closing pause and takes no keystream. Lengths above MAX_BITS (32) are treated as MAX_BITS.
- R9: `start` is captured only while idle. `frame_data` and `frame_len` are latched at that point. A `start` during a frame does not change the frame in progress and does not queue another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_data | input | MAX_BITS | Frame word, bit 0 sent first |
| frame_len | input | LEN_W | Number of bits to send (0 to MAX_BITS, larger values clipped) |
| start | input | 1 | Begin a frame; captured only while idle |
| ks_valid | input | 1 | Keystream bit available |
| ks_bit | input | 1 | Keystream bit, held while valid |
| ks_ready | output | 1 | Block accepts a keystream bit this cycle |
| carrier_on | output | 1 | Carrier enable, low during pauses |
| done | output | 1 | One-cycle pulse when the closing pause ends |

## Verification
The carrier's behaviour is checked as a sequence of run lengths, sampled once per cycle on the falling clock edge. The idle run before a frame must match max(GUARD_T, wait + 2). That value follows from `start` being driven one nanosecond after a rising edge and sampled on the next edge. Each low run must be PAUSE_T, plus the number of starved ready cycles when a stall was injected. Each high run must be the on-time for frame bit XOR keystream bit. The frame's results are read one rising edge after `done` is seen. By then the closing pause's length, the number of keystream bits taken and the single `done` pulse are all final.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_PAUSE,
    ST_MARK,
    ST_TAIL
  } pwtx_state_t;

  typedef enum logic [1:0] {
    DL_HOLD,
    DL_SET,
    DL_ADD
  } dl_op_t;

endpackage

// File: rtl/pwtx_timebase.sv
module pwtx_timebase #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] now_nx
);

  logic [TICK_W-1:0] now_q;

  assign now_nx = now_q + TICK_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_nx;
  end

endmodule

// File: rtl/pwtx_deadline.sv
module pwtx_deadline
  import pwtx_pkg::*;
#(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] now_nx,
  input  dl_op_t            op,
  input  logic [TICK_W-1:0] dur,
  output logic              due,
  output logic [TICK_W-1:0] elapsed
);

  logic [TICK_W-1:0] mark_q;

  // the edge whose post-edge time equals the mark is the deadline edge
  assign due     = (now_nx == mark_q);
  assign elapsed = now_nx - mark_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= '0;
    end else begin
      unique case (op)
        DL_SET:  mark_q <= now_nx + dur;
        DL_ADD:  mark_q <= mark_q + dur;
        default: mark_q <= mark_q;
      endcase
    end
  end

endmodule

// File: rtl/pwtx_shifter.sv
module pwtx_shifter #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic [MAX_BITS-1:0] data_in,
  input  logic [LEN_W-1:0]    len_in,
  output logic                head_bit,
  output logic                on_last,
  output logic                is_empty,
  output logic                in_empty
);

  logic [MAX_BITS-1:0] shreg_q;
  logic [LEN_W-1:0]    rem_q;
  logic [LEN_W-1:0]    len_clip;

  generate
    if (((1 << LEN_W) - 1) > MAX_BITS) begin : g_clip
      assign len_clip = (len_in > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : len_in;
    end else begin : g_pass
      assign len_clip = len_in;
    end
  endgenerate

  assign head_bit = shreg_q[0];
  assign on_last  = (rem_q == LEN_W'(1));
  assign is_empty = (rem_q == '0);
  assign in_empty = (len_in == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      rem_q   <= '0;
    end else if (load) begin
      shreg_q <= data_in;
      rem_q   <= len_clip;
    end else if (step) begin
      shreg_q <= shreg_q >> 1;
      rem_q   <= rem_q - LEN_W'(1);
    end
  end

endmodule

// File: rtl/pwtx_pause_tx.sv
module pwtx_pause_tx
  import pwtx_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = $clog2(MAX_BITS + 1),
  parameter int TICK_W   = 16,
  parameter int PAUSE_T  = 30,
  parameter int ONE_T    = 150,
  parameter int ZERO_T   = 90,
  parameter int GUARD_T  = 330
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_BITS-1:0] frame_data,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic                start,
  input  logic                ks_valid,
  input  logic                ks_bit,
  output logic                ks_ready,
  output logic                carrier_on,
  output logic                done
);

  localparam logic [TICK_W-1:0] D_PAUSE = TICK_W'(PAUSE_T);
  localparam logic [TICK_W-1:0] D_HI1   = TICK_W'(ONE_T - PAUSE_T);
  localparam logic [TICK_W-1:0] D_HI0   = TICK_W'(ZERO_T - PAUSE_T);
  localparam logic [TICK_W-1:0] D_GUARD = TICK_W'(GUARD_T);

  pwtx_state_t       st_q, st_d;
  logic              car_q, car_d;
  logic              done_q, done_d;
  logic              guard_q, guard_d;
  logic              late_q, late_d;
  logic              busy;

  logic [TICK_W-1:0] now_nx;
  logic [TICK_W-1:0] elapsed;
  logic [TICK_W-1:0] dl_dur;
  logic [TICK_W-1:0] mark_len;
  dl_op_t            dl_op;
  logic              due;

  logic              sh_load, sh_step;
  logic              head_bit, on_last, is_empty, in_empty;
  logic              hit_guard, guard_ok, take, tx_bit;

  pwtx_timebase #(.TICK_W(TICK_W)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .now_nx (now_nx)
  );

  pwtx_deadline #(.TICK_W(TICK_W)) u_deadline (
    .clk     (clk),
    .rst_n   (rst_n),
    .now_nx  (now_nx),
    .op      (dl_op),
    .dur     (dl_dur),
    .due     (due),
    .elapsed (elapsed)
  );

  pwtx_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .step     (sh_step),
    .data_in  (frame_data),
    .len_in   (frame_len),
    .head_bit (head_bit),
    .on_last  (on_last),
    .is_empty (is_empty),
    .in_empty (in_empty)
  );

  assign busy       = (st_q != ST_IDLE);
  assign hit_guard  = (st_q == ST_IDLE) && (elapsed == D_GUARD);
  assign guard_ok   = guard_q || hit_guard;
  assign ks_ready   = (st_q == ST_PAUSE) && (due || late_q);
  assign take       = ks_ready && ks_valid;
  assign tx_bit     = head_bit ^ ks_bit;
  assign mark_len   = tx_bit ? D_HI1 : D_HI0;
  assign carrier_on = car_q;
  assign done       = done_q;

  always_comb begin
    st_d    = st_q;
    car_d   = car_q;
    done_d  = 1'b0;
    guard_d = guard_q;
    late_d  = late_q;
    dl_op   = DL_HOLD;
    dl_dur  = D_PAUSE;
    sh_load = 1'b0;
    sh_step = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        guard_d = guard_ok;
        if (start) begin
          sh_load = 1'b1;
          if (guard_ok) begin
            car_d  = 1'b0;
            dl_op  = DL_SET;
            dl_dur = D_PAUSE;
            st_d   = in_empty ? ST_TAIL : ST_PAUSE;
          end else begin
            dl_op  = DL_ADD;
            dl_dur = D_GUARD;
            st_d   = ST_GUARD;
          end
        end
      end

      ST_GUARD: begin
        if (due) begin
          car_d  = 1'b0;
          dl_op  = DL_ADD;
          dl_dur = D_PAUSE;
          st_d   = is_empty ? ST_TAIL : ST_PAUSE;
        end
      end

      ST_PAUSE: begin
        if (take) begin
          car_d  = 1'b1;
          dl_op  = late_q ? DL_SET : DL_ADD;
          dl_dur = mark_len;
          late_d = 1'b0;
          st_d   = ST_MARK;
        end else if (due) begin
          late_d = 1'b1;
        end
      end

      ST_MARK: begin
        if (due) begin
          car_d   = 1'b0;
          dl_op   = DL_ADD;
          dl_dur  = D_PAUSE;
          sh_step = 1'b1;
          st_d    = on_last ? ST_TAIL : ST_PAUSE;
        end
      end

      ST_TAIL: begin
        if (due) begin
          car_d   = 1'b1;
          done_d  = 1'b1;
          guard_d = 1'b0;
          st_d    = ST_IDLE;
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      car_q   <= 1'b1;
      done_q  <= 1'b0;
      guard_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      car_q   <= car_d;
      done_q  <= done_d;
      guard_q <= guard_d;
      late_q  <= late_d;
    end
  end

endmodule

// File: rtl/pwtx_checker.sv
module pwtx_checker (
  input logic clk,
  input logic rst_n,
  input logic carrier_on,
  input logic done,
  input logic ks_ready,
  input logic ks_valid,
  input logic busy
);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> carrier_on);

  // R4
  ready_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_ready |-> !carrier_on);

  // R4
  one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_ready && ks_valid) |=> (carrier_on && !ks_ready));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (carrier_on && !$past(carrier_on) && !busy));

  // R9
  fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_on) |-> busy);

endmodule

bind pwtx_pause_tx pwtx_checker u_pwtx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .carrier_on (carrier_on),
  .done       (done),
  .ks_ready   (ks_ready),
  .ks_valid   (ks_valid),
  .busy       (busy)
);

// File: tb/test_pwtx_pause_tx.sv
module test_pwtx_pause_tx;

  localparam int MAX_BITS = 32;
  localparam int LEN_W    = 6;
  localparam int PAUSE_T  = 30;
  localparam int ONE_T    = 150;
  localparam int ZERO_T   = 90;
  localparam int GUARD_T  = 330;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [MAX_BITS-1:0] frame_data = '0;
  logic [LEN_W-1:0]    frame_len = '0;
  logic                start = 1'b0;
  logic                ks_valid = 1'b0;
  logic                ks_bit = 1'b0;
  logic                ks_ready;
  logic                carrier_on;
  logic                done;

  int checks = 0;
  int fails = 0;

  int   runs_len [0:127];
  int   nruns = 0;
  int   runlen = 0;
  logic prev = 1'b1;
  int   done_cnt = 0;

  logic [31:0] ks_word = '0;
  int ks_idx = 0;
  int stall_idx = 99;
  int stall_n = 0;
  int scnt = 0;

  always #10 clk = ~clk;

  pwtx_pause_tx i_pwtx_pause_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_data (frame_data),
    .frame_len  (frame_len),
    .start      (start),
    .ks_valid   (ks_valid),
    .ks_bit     (ks_bit),
    .ks_ready   (ks_ready),
    .carrier_on (carrier_on),
    .done       (done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    if (l > MAX_BITS) return MAX_BITS;
    return l;
  endfunction

  function automatic int hi_len(input bit d, input bit k);
    return (d ^ k) ? (ONE_T - PAUSE_T) : (ZERO_T - PAUSE_T);
  endfunction

  // carrier run-length monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      prev   = 1'b1;
      runlen = 0;
    end else begin
      if (done) begin
        done_cnt++;
        chk(carrier_on && !prev, "R6 done with carrier return", int'(carrier_on), 1);
      end
      if (carrier_on != prev) begin
        if (nruns < 128) runs_len[nruns] = runlen;
        nruns++;
        runlen = 1;
      end else begin
        runlen++;
      end
      prev = carrier_on;
    end
  end

  // keystream source with optional starvation at one bit index
  initial begin
    forever begin
      bit take;
      bit starve;
      @(negedge clk);
      take   = ks_ready && ks_valid;
      starve = ks_ready && !ks_valid;
      @(posedge clk);
      #2;
      if (take) ks_idx++;
      if (starve) scnt++;
      ks_valid = !(ks_idx == stall_idx && scnt < stall_n);
      ks_bit   = (ks_idx < 32) ? ks_word[ks_idx] : 1'b0;
    end
  end

  task automatic run_frame(input logic [31:0] d, input int len, input logic [31:0] k,
                           input int wait_w, input int st_i, input int st_n,
                           input bit poke, input bit gap_chk);
    int le;
    int g;
    repeat (wait_w) @(posedge clk);
    #1;
    frame_data = d;
    frame_len  = LEN_W'(len);
    ks_word    = k;
    ks_idx     = 0;
    scnt       = 0;
    stall_idx  = st_i;
    stall_n    = st_n;
    nruns      = 0;
    done_cnt   = 0;
    start      = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    if (poke) begin
      repeat (100) @(posedge clk);
      #1;
      start      = 1'b1;
      frame_data = ~d;
      frame_len  = LEN_W'(5);
      @(posedge clk);
      #1 start = 1'b0;
    end
    do @(negedge clk); while (!done);
    @(posedge clk);
    #1;
    le = eff_len(len);
    chk(nruns == 2 * le + 2, "R2 R8 R9 carrier run count", nruns, 2 * le + 2);
    if (nruns == 2 * le + 2) begin
      if (gap_chk) begin
        g = (wait_w + 2 > GUARD_T) ? wait_w + 2 : GUARD_T;
        chk(runs_len[0] == g, "R7 idle gap before frame", runs_len[0], g);
      end
      for (int i = 0; i < le; i++) begin
        int ep;
        int eh;
        ep = PAUSE_T + ((i == st_i) ? st_n : 0);
        eh = hi_len(d[i], k[i]);
        chk(runs_len[1 + 2 * i] == ep, (i == st_i) ? "R5 stretched pause" : "R2 bit pause",
            runs_len[1 + 2 * i], ep);
        chk(runs_len[2 + 2 * i] == eh, "R3 R2 whitened bit on-time", runs_len[2 + 2 * i], eh);
      end
      chk(runs_len[2 * le + 1] == PAUSE_T, "R6 closing pause", runs_len[2 * le + 1], PAUSE_T);
    end
    chk(ks_idx == le, "R4 R8 keystream bits taken", ks_idx, le);
    chk(done_cnt == 1, "R6 done pulses", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(carrier_on == 1'b1, "R1 carrier after reset", int'(carrier_on), 1);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(ks_ready == 1'b0, "R1 ks_ready after reset", int'(ks_ready), 0);

    // handshake-sized frames
    run_frame(32'h0000_0055, 7, 32'h0000_0000, 0, 99, 0, 1'b0, 1'b0);
    run_frame(32'h0000_003D, 6, 32'h0000_0026, 0, 99, 0, 1'b0, 1'b1);   // R7 start during guard
    // R8 empty frame
    run_frame(32'h1234_5678, 0, 32'hFFFF_FFFF, 20, 99, 0, 1'b0, 1'b1);
    // R8 clipped length, alternating whitening
    run_frame(32'hFFFF_FFFF, 40, 32'hAAAA_AAAA, 5, 99, 0, 1'b0, 1'b1);
    // R5 keystream starvation on bit 0 and bit 2
    run_frame(32'h0000_0F0F, 12, 32'h0000_0333, 0, 0, 9, 1'b0, 1'b1);
    run_frame(32'h0012_3456, 23, 32'h0065_4321, 0, 2, 17, 1'b0, 1'b1);
    // R9 start pulsed mid-frame, then a long idle proves nothing was queued
    run_frame(32'h0000_02A5, 10, 32'h0000_0111, 0, 99, 0, 1'b1, 1'b1);
    run_frame(32'h0000_0001, 1, 32'h0000_0000, GUARD_T + 100, 99, 0, 1'b0, 1'b1);

    for (int n = 0; n < 10; n++) begin
      int len;
      int si;
      int sn;
      int ww;
      logic [31:0] dd;
      logic [31:0] kk;
      len = $urandom_range(0, 34);
      dd  = $urandom;
      kk  = $urandom;
      ww  = $urandom_range(0, 700);
      sn  = $urandom_range(1, 40);
      si  = 99;
      if (len > 0 && $urandom_range(0, 2) == 0) si = $urandom_range(0, eff_len(len) - 1);
      run_frame(dd, len, kk, ww, si, sn, 1'b0, 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule